// File: doc/BRIEF.md
# Uncore Performance Counter Unit

This block counts occurrences of hardware events inside an off-core subsystem such as a shared cache, an I/O bridge or a memory controller. It has four 32-bit counters. Each counter picks one event source through its own 8-bit selector code. The choice can be the clock itself, a divided clock, or one of a bank of event strobe inputs. Strobe events can be filtered by the identity of the agent that caused them, through a 64-bit mask in which a set bit suppresses that agent.

Software drives the unit through a simple 32-bit register port that has a single-cycle write strobe and a combinational read. Through this port it starts and stops all counting, zeroes the counters, sets and clears the per-counter enables and interrupt enables, and clears overflow flags. A counter that wraps raises its overflow flag. An enabled flag holds a single level-sensitive interrupt high until software clears the flag.

Top module: `uncore_perf_mon`

## Requirements
- R1: After reset every counter, selector, mask, enable, interrupt enable, overflow flag and the control register read as zero, and `irq_o` is low.
- R2: Counter n (n = 0..3) is read and written as a full 32-bit word at byte offset 0x000 + 4n. Its selector is at 0x400 + 4n and keeps only the low 8 bits; the upper 24 bits read as zero.
- R3: A counter advances by exactly one on each clock in which all four conditions hold: control bit 0 (offset 0xE04) is 1, its own enable is set, its selected event is active, and its filter passes. It holds its value in every other clock.
- R4: Selector codes behave as follows. 0x00 is active on every clock. 0x01 is active on every 64th clock in which the global enable is 1. 0x02 to 0x11 select strobe `evt_i[code-2]`. Any other code is never active.
- R5: The agent mask is split across two registers: 0xA00 covers agents 0 to 31 and 0xA04 covers agents 32 to 63, with bit k standing for agent k. A strobe event passes only when the mask bit for `agent_id_i` is 0. Codes 0x00 and 0x01 ignore the mask.
- R6: Counter enables are set at 0xC00 and cleared at 0xC20. Interrupt enables are set at 0xC40 and cleared at 0xC60. Bit n of the write data acts on counter n, and a 0 bit has no effect. A read of either address in a pair returns the current enables in bits 3:0.
- R7: When a counter steps from 0xFFFFFFFF to 0, bit n of the overflow register at 0xC80 is set. Writing 1 to that bit clears it. If a wrap and a clearing write fall in the same clock, the flag stays set.
- R8: Writing 1 to control bit 1 zeroes all four counters and the divide-by-64 prescaler. Bit 1 always reads as 0, and bit 0 reads back as written.
- R9: A software write to a counter takes priority over an increment in the same clock: the counter takes the written value and no overflow flag is set.
- R10: `irq_o` is high exactly when some counter has both its overflow flag and its interrupt enable set, and it stays high until one of the two is cleared.
- R11: A read of any address not listed above returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| addr_i | input | 12 | Register byte address, used for both reads and writes |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for the word at `addr_i`, combinational |
| evt_i | input | 16 | Event strobes, one per source |
| agent_id_i | input | 6 | Agent that caused the current strobe events |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
The bench provokes two same-clock collisions between software and hardware.

- **Counter write against increment.** While a counter is counting, software writes it, and in one case the counter sits at 0xFFFFFFFF. The bench expects the written value plus one increment from the following clock, and no overflow flag.
- **Overflow clear against wrap.** A counter is left at 0xFFFFFFFF with counting enabled, so that the write-one-to-clear of its overflow flag lands on the clock of the wrap. The bench expects the flag to remain set.

In both cases the bench places the writes one clock apart, starting from the clock on which counting is enabled. The result is judged only through register reads and `irq_o`.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CNT      = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SEL      = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 12'hA00;
  localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 12'hA04;
  localparam logic [ADDR_W-1:0] OFF_CEN_SET  = 12'hC00;
  localparam logic [ADDR_W-1:0] OFF_CEN_CLR  = 12'hC20;
  localparam logic [ADDR_W-1:0] OFF_IEN_SET  = 12'hC40;
  localparam logic [ADDR_W-1:0] OFF_IEN_CLR  = 12'hC60;
  localparam logic [ADDR_W-1:0] OFF_OVF      = 12'hC80;
  localparam logic [ADDR_W-1:0] OFF_CTRL     = 12'hE04;

  localparam logic [7:0] SEL_CYCLE = 8'h00;
  localparam logic [7:0] SEL_DIV   = 8'h01;
  localparam logic [7:0] SEL_BASE  = 8'h02;

  localparam int DIV_W = 6;

  typedef struct packed {
    logic run;
    logic zero;
  } ctrl_wr_t;
endpackage

// File: rtl/perf_evt_sel.sv
module perf_evt_sel #(
  parameter int NUM_EVT = 16
) (
  input  logic [7:0]         code_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               div_tick_i,
  input  logic               agent_ok_i,
  output logic               hit_o
);
  import perf_mon_pkg::*;
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [7:0] rel;
  assign rel = code_i - SEL_BASE;

  always_comb begin
    hit_o = 1'b0;
    if (code_i == SEL_CYCLE) hit_o = 1'b1;
    else if (code_i == SEL_DIV) hit_o = div_tick_i;
    else if (code_i >= SEL_BASE && rel < 8'(NUM_EVT))
      hit_o = evt_i[rel[IDX_W-1:0]] & agent_ok_i;
  end
endmodule

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = inc_i && !wr_i && !clr_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  // R9
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/uncore_perf_mon.sv
module uncore_perf_mon #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 16,
  parameter int AGENT_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [11:0]        addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [AGENT_W-1:0] agent_id_i,
  output logic               irq_o
);
  import perf_mon_pkg::*;
  localparam int AGENTS = 1 << AGENT_W;
  localparam int MASK_W = 64;

  logic [CNT_W-1:0]   cnt      [NUM_CNT];
  logic [7:0]         sel_q    [NUM_CNT];
  logic [NUM_CNT-1:0] cen_q, ien_q, ovf_q;
  logic [NUM_CNT-1:0] hit, inc, wrap, cnt_wr;
  logic [MASK_W-1:0]  mask_q;
  logic               run_q;
  logic [DIV_W-1:0]   div_q;
  logic               div_tick, agent_ok;
  ctrl_wr_t           cw;

  function automatic logic hit_addr(input logic [11:0] a, input logic [11:0] off);
    return wr_en_i && (a == off);
  endfunction

  assign cw.run  = hit_addr(addr_i, OFF_CTRL);
  assign cw.zero = cw.run && wdata_i[1];

  // control and prescaler
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      div_q <= '0;
    end else begin
      if (cw.run) run_q <= wdata_i[0];
      if (cw.zero)     div_q <= '0;
      else if (run_q)  div_q <= div_q + 1'b1;
    end
  end
  assign div_tick = run_q && (&div_q);

  // agent mask, enables, overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      cen_q  <= '0;
      ien_q  <= '0;
      ovf_q  <= '0;
    end else begin
      if (hit_addr(addr_i, OFF_MASK_LO)) mask_q[31:0]  <= wdata_i;
      if (hit_addr(addr_i, OFF_MASK_HI)) mask_q[63:32] <= wdata_i;
      if (hit_addr(addr_i, OFF_CEN_SET)) cen_q <= cen_q |  wdata_i[NUM_CNT-1:0];
      if (hit_addr(addr_i, OFF_CEN_CLR)) cen_q <= cen_q & ~wdata_i[NUM_CNT-1:0];
      if (hit_addr(addr_i, OFF_IEN_SET)) ien_q <= ien_q |  wdata_i[NUM_CNT-1:0];
      if (hit_addr(addr_i, OFF_IEN_CLR)) ien_q <= ien_q & ~wdata_i[NUM_CNT-1:0];
      if (hit_addr(addr_i, OFF_OVF))
        ovf_q <= (ovf_q & ~wdata_i[NUM_CNT-1:0]) | wrap;
      else
        ovf_q <= ovf_q | wrap;
    end
  end

  logic [AGENTS-1:0] mask_used;
  assign mask_used = mask_q[AGENTS-1:0];
  assign agent_ok  = !mask_used[agent_id_i];

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q[n] <= '0;
      else if (hit_addr(addr_i, OFF_SEL + 12'(4*n))) sel_q[n] <= wdata_i[7:0];
    end

    perf_evt_sel #(.NUM_EVT(NUM_EVT)) u_sel (
      .code_i     (sel_q[n]),
      .evt_i      (evt_i),
      .div_tick_i (div_tick),
      .agent_ok_i (agent_ok),
      .hit_o      (hit[n])
    );

    assign inc[n]    = run_q && cen_q[n] && hit[n];
    assign cnt_wr[n] = hit_addr(addr_i, OFF_CNT + 12'(4*n));

    perf_cnt_slice #(.CNT_W(CNT_W)) u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[n]),
      .clr_i   (cw.zero),
      .wr_i    (cnt_wr[n]),
      .wdata_i (wdata_i[CNT_W-1:0]),
      .cnt_o   (cnt[n]),
      .wrap_o  (wrap[n])
    );

    // R7
    wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap[n] |=> ovf_q[n]);

    // R8
    zero_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cw.zero |=> cnt[n] == '0);
  end

  assign irq_o = |(ovf_q & ien_q);

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_MASK_LO: rdata_o = mask_q[31:0];
      OFF_MASK_HI: rdata_o = mask_q[63:32];
      OFF_CEN_SET, OFF_CEN_CLR: rdata_o[NUM_CNT-1:0] = cen_q;
      OFF_IEN_SET, OFF_IEN_CLR: rdata_o[NUM_CNT-1:0] = ien_q;
      OFF_OVF:     rdata_o[NUM_CNT-1:0] = ovf_q;
      OFF_CTRL:    rdata_o[0] = run_q;
      default: begin
        for (int n = 0; n < NUM_CNT; n++) begin
          if (addr_i == OFF_CNT + 12'(4*n)) rdata_o[CNT_W-1:0] = cnt[n];
          if (addr_i == OFF_SEL + 12'(4*n)) rdata_o[7:0] = sel_q[n];
        end
      end
    endcase
  end

  // R6
  cen_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_addr(addr_i, OFF_CEN_SET) |=>
      ((cen_q & $past(wdata_i[NUM_CNT-1:0])) == $past(wdata_i[NUM_CNT-1:0])));

  // R6
  ien_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_addr(addr_i, OFF_IEN_CLR) |=> ((ien_q & $past(wdata_i[NUM_CNT-1:0])) == '0));

  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_en_i) |=> irq_o);
endmodule

// File: tb/uncore_perf_mon_tb.sv
module uncore_perf_mon_tb;
  logic        clk = 0, rst_ni = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] evt = '0;
  logic [5:0]  agent = '0;
  logic        irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  uncore_perf_mon u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .agent_id_i(agent), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0]  code;
    logic [15:0] strobe;
    logic [5:0]  who;
    logic [31:0] mask0;
    logic [31:0] k;
    logic [31:0] exp;
  } vec_t;

  // counting edges = k + 1 (enable write edge excluded, disable write edge included)
  localparam vec_t VEC [10] = '{
    '{8'h00, 16'h0000, 6'd0, 32'h0,        32'd9,   32'd10}, // R4 cycle
    '{8'h01, 16'h0000, 6'd0, 32'h0,        32'd127, 32'd2},  // R4 div64
    '{8'h02, 16'h0001, 6'd0, 32'h0,        32'd19,  32'd20}, // R3 strobe 0
    '{8'h05, 16'h0008, 6'd0, 32'h0,        32'd4,   32'd5},  // R4 strobe 3
    '{8'h05, 16'h0004, 6'd0, 32'h0,        32'd4,   32'd0},  // R4 other strobe
    '{8'h02, 16'h0001, 6'd3, 32'h8,        32'd9,   32'd0},  // R5 filtered
    '{8'h02, 16'h0001, 6'd4, 32'h8,        32'd9,   32'd10}, // R5 passes
    '{8'h20, 16'hFFFF, 6'd0, 32'h0,        32'd9,   32'd0},  // R4 unknown code
    '{8'h00, 16'h0000, 6'd0, 32'hFFFFFFFF, 32'd9,   32'd10}, // R5 cycle unfiltered
    '{8'h11, 16'h8000, 6'd0, 32'h0,        32'd2,   32'd3}   // R4 last strobe
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    for (int n = 0; n < 4; n++) begin
      rchk("R1 cnt", 12'(4*n), 0);
      rchk("R1 sel", 12'h400 + 12'(4*n), 0);
    end
    rchk("R1 mask0", 12'hA00, 0);
    rchk("R1 mask1", 12'hA04, 0);
    rchk("R1 cen", 12'hC00, 0);
    rchk("R1 ien", 12'hC40, 0);
    rchk("R1 ovf", 12'hC80, 0);
    rchk("R1 ctrl", 12'hE04, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 access
    wr(12'h004, 32'h12345678);
    rchk("R2 cnt1", 12'h004, 32'h12345678);
    wr(12'h404, 32'hABCD);
    rchk("R2 sel1", 12'h404, 32'hCD);

    // R6 set/clear
    wr(12'hC00, 32'h5);
    rchk("R6 cen set", 12'hC00, 32'h5);
    rchk("R6 cen via clr", 12'hC20, 32'h5);
    wr(12'hC00, 32'h2);
    rchk("R6 cen zeros", 12'hC00, 32'h7);
    wr(12'hC20, 32'h4);
    rchk("R6 cen clr", 12'hC20, 32'h3);
    wr(12'hC40, 32'hA);
    rchk("R6 ien set", 12'hC60, 32'hA);
    wr(12'hC60, 32'h8);
    rchk("R6 ien clr", 12'hC40, 32'h2);
    wr(12'hC20, 32'hF);
    wr(12'hC60, 32'hF);

    // R11 unmapped
    rchk("R11 unmapped", 12'h100, 0);
    rchk("R11 unmapped", 12'hFFC, 0);

    // R3 global off blocks counting
    wr(12'h000, 32'h0);
    wr(12'hC00, 32'h1);
    repeat (10) @(negedge clk);
    rchk("R3 global off", 12'h000, 0);

    // vector table on counter 0
    foreach (VEC[i]) begin
      wr(12'hE04, 32'h2);
      wr(12'h400, {24'b0, VEC[i].code});
      wr(12'hA00, VEC[i].mask0);
      evt = VEC[i].strobe; agent = VEC[i].who;
      wr(12'hE04, 32'h1);
      repeat (VEC[i].k) @(negedge clk);
      wr(12'hE04, 32'h0);
      rchk($sformatf("R3 R4 R5 vec%0d", i), 12'h000, VEC[i].exp);
      rchk("R3 disabled counter idle", 12'h008, 0);
    end
    wr(12'hA00, 32'h0);

    // R5 upper mask word
    wr(12'hA04, 32'h100);
    wr(12'h400, 32'h02);
    evt = 16'h1; agent = 6'd40;
    wr(12'hE04, 32'h3);
    repeat (4) @(negedge clk);
    wr(12'hE04, 32'h0);
    rchk("R5 agent40 masked", 12'h000, 0);
    agent = 6'd41;
    wr(12'hE04, 32'h3);
    repeat (4) @(negedge clk);
    wr(12'hE04, 32'h0);
    rchk("R5 agent41 counted", 12'h000, 5);
    evt = '0;

    // R8 control readback and zeroing
    wr(12'hE04, 32'h3);
    rchk("R8 ctrl readback", 12'hE04, 32'h1);
    wr(12'hE04, 32'h0);
    wr(12'hE04, 32'h2);
    rchk("R8 zeroed", 12'h000, 0);

    // R7 R10 wrap on counter 1
    wr(12'hC20, 32'hF);
    wr(12'h404, 32'h00);
    wr(12'h004, 32'hFFFFFFFE);
    wr(12'hC00, 32'h2);
    wr(12'hC40, 32'h2);
    wr(12'hE04, 32'h1);
    @(negedge clk);
    wr(12'hE04, 32'h0);
    rchk("R7 wrapped", 12'h004, 0);
    rchk("R7 ovf set", 12'hC80, 32'h2);
    chk("R10 irq on", {31'b0, irq}, 1);
    wr(12'hC60, 32'h2);
    chk("R10 irq masked", {31'b0, irq}, 0);
    rchk("R10 flag kept", 12'hC80, 32'h2);
    wr(12'hC40, 32'h2);
    chk("R10 irq back", {31'b0, irq}, 1);
    wr(12'hC80, 32'h1);
    rchk("R7 other bit no clear", 12'hC80, 32'h2);
    wr(12'hC80, 32'h2);
    rchk("R7 w1c", 12'hC80, 0);
    chk("R10 irq off", {31'b0, irq}, 0);

    // R7 clear coincides with wrap
    wr(12'h004, 32'hFFFFFFFF);
    wr(12'hE04, 32'h1);
    wr(12'hC80, 32'h2);
    wr(12'hE04, 32'h0);
    rchk("R7 wrap beats clear", 12'hC80, 32'h2);
    rchk("R7 cnt after", 12'h004, 32'h1);
    wr(12'hC80, 32'h2);

    // R9 write beats increment
    wr(12'hE04, 32'h1);
    wr(12'h004, 32'h100);
    wr(12'hE04, 32'h0);
    rchk("R9 write wins", 12'h004, 32'h101);
    wr(12'h004, 32'hFFFFFFFF);
    wr(12'hE04, 32'h1);
    wr(12'h004, 32'h5);
    wr(12'hE04, 32'h0);
    rchk("R9 no wrap cnt", 12'h004, 32'h6);
    rchk("R9 no ovf", 12'hC80, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule